// File: doc/BRIEF.md
# Fractional-N PLL Output Frequency Calculator

This block works out the output frequency of a fractional-N synthesizer from its 32-bit control word and the frequency of its reference clock. It decodes four fields from the word: a pre-divider, an integer multiplier, a signed fractional numerator and a fractional denominator. The integer multiplier is held at a minimum of 5, and the numerator is sign-extended. The block then forms a dividend and a divisor from these fields and divides them in a multi-cycle unsigned divider.

The reference is scaled down by 1024 before the arithmetic and the quotient is scaled back up by 1024 afterwards. The answer is therefore a multiple of 1024 and carries the truncation of both steps. A caller pulses a start input with the operands present in that cycle. It then waits for the done pulse and reads a 32-bit result, which stays put until the next accepted start.

Top module: `pll_freq_calc`

## Requirements
- R1: The control word fields are: numerator in bits [9:0], integer multiplier in bits [13:10], denominator code in bits [25:16] and pre-divider code in bits [29:26]. The effective denominator is its code plus 1 and the effective pre-divider is its code plus 1. Bits 14, 15, 30 and 31 have no effect on the result.
- R2: An integer multiplier below 5 is used as 5.
- R3: The numerator is a 10-bit two's-complement value (range -512 to 511).
- R4: The result is `((2 * (ref >> 10) * (mfi * den + num)) / (den * pre)) << 10`, with truncating division. For example, a reference of 26,000,000 with pre-divider code 1, denominator code 0, multiplier 6 and numerator 0 gives 155,996,160.
- R5: Intermediate products are exact to 64 bits. The 32-bit result keeps only the low 32 bits of the scaled quotient.
- R6: When `mfi * den + num` is negative, the result is 0.
- R7: `busy_o` is high for exactly 64 cycles, starting the cycle after an accepted start. `done_o` is high for the single cycle that follows, with `busy_o` low.
- R8: A start received while `busy_o` is high is ignored. The run in progress completes with the result of its own operands.
- R9: `freq_o` holds its value from the done cycle until the next accepted start. A start in the done cycle itself is accepted.
- R10: After reset, `busy_o` and `done_o` are low and `freq_o` is 0.
- R11: The divisor loaded into the divider is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a calculation with the operands sampled this cycle |
| ctrl_word_i | input | 32 | Synthesizer control word |
| ref_freq_i | input | 32 | Reference frequency in Hz |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle pulse when the result is ready |
| freq_o | output | 32 | Computed output frequency in Hz |

## Verification
A wrong step count in the divider shows up as a done pulse that arrives early or late against the fixed 65-cycle latency. It is caught on the very first calculation. A corrupted partial remainder or shifted quotient bit gives a wrong `freq_o` in that same done cycle. The vectors include unit divisors, large divisors and inexact quotients, so every restore path is exercised. A field decode error, a missing clamp or a missing sign extension changes the result only for control words that reach that field. For that reason each of those cases has a vector of its own.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int CW_W    = 32;
  localparam int NUM_LSB = 0;
  localparam int NUM_W   = 10;
  localparam int MUL_LSB = 10;
  localparam int MUL_W   = 4;
  localparam int DEN_LSB = 16;
  localparam int DEN_W   = 10;
  localparam int PRE_LSB = 26;
  localparam int PRE_W   = 4;
  localparam int MUL_MIN = 5;

  typedef struct packed {
    logic [PRE_W:0]     pre_eff;
    logic [DEN_W:0]     den_eff;
    logic [MUL_W-1:0]   mul_eff;
    logic [NUM_W-1:0]   num_raw;
  } pll_fields_t;
endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
  import pll_calc_pkg::*;
(
  input  logic [CW_W-1:0] ctrl_word_i,
  output pll_fields_t     fields_o
);
  logic [MUL_W-1:0] mul_raw;
  logic [DEN_W-1:0] den_raw;
  logic [PRE_W-1:0] pre_raw;

  always_comb begin
    mul_raw          = ctrl_word_i[MUL_LSB +: MUL_W];
    den_raw          = ctrl_word_i[DEN_LSB +: DEN_W];
    pre_raw          = ctrl_word_i[PRE_LSB +: PRE_W];
    fields_o.num_raw = ctrl_word_i[NUM_LSB +: NUM_W];
    fields_o.mul_eff = (int'(mul_raw) < MUL_MIN) ? MUL_W'(MUL_MIN) : mul_raw;
    fields_o.den_eff = (DEN_W+1)'(den_raw) + (DEN_W+1)'(1);
    fields_o.pre_eff = (PRE_W+1)'(pre_raw) + (PRE_W+1)'(1);
  end
endmodule

// File: rtl/pll_operand_mult.sv
module pll_operand_mult
  import pll_calc_pkg::*;
#(
  parameter int REF_W    = 32,
  parameter int SCALE_SH = 10,
  parameter int DVD_W    = 64,
  parameter int DVS_W    = 16
) (
  input  pll_fields_t      fields_i,
  input  logic [REF_W-1:0] ref_freq_i,
  output logic [DVD_W-1:0] dividend_o,
  output logic [DVS_W-1:0] divisor_o
);
  localparam int TERM_W = MUL_W + DEN_W + 3;

  logic [TERM_W-1:0] prod_u;
  logic [TERM_W-1:0] num_ext;
  logic [TERM_W-1:0] term;
  logic [REF_W-1:0]  ref_scaled;

  always_comb begin
    prod_u     = TERM_W'(fields_i.mul_eff) * TERM_W'(fields_i.den_eff);
    num_ext    = {{(TERM_W-NUM_W){fields_i.num_raw[NUM_W-1]}}, fields_i.num_raw};
    term       = prod_u + num_ext;
    ref_scaled = ref_freq_i >> SCALE_SH;
    if (term[TERM_W-1]) begin
      dividend_o = '0;
    end else begin
      dividend_o = (DVD_W'(ref_scaled) * DVD_W'(term)) << 1;
    end
    divisor_o = DVS_W'(fields_i.den_eff) * DVS_W'(fields_i.pre_eff);
  end
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int DVD_W = 64,
  parameter int DVS_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVD_W-1:0] quotient_o
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVS_W-1:0] rem_q, rem_d;
  logic [DVD_W-1:0] quo_q, quo_d;
  logic [DVS_W-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             dp_en;
  logic [DVS_W:0]   shifted;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    shifted = {rem_q, quo_q[DVD_W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = (shifted >= {1'b0, dvs_q});
    dp_en   = load_i | busy_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (load_i) begin
      rem_d  = '0;
      quo_d  = dividend_i;
      dvs_d  = divisor_i;
      cnt_d  = CNT_W'(DVD_W);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = fits ? diff[DVS_W-1:0] : shifted[DVS_W-1:0];
      quo_d = {quo_q[DVD_W-2:0], fits};
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (dp_en) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign quotient_o = quo_q;

  // R11: a zero divisor would make every quotient bit 1
  assert_div_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    load_i |-> (divisor_i != '0));

  // R7: done is a single-cycle pulse and never overlaps busy
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));

  // R9: quotient register is frozen while idle and no load arrives
  assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy_q && !load_i) |=> $stable(quo_q));
endmodule

// File: rtl/pll_freq_calc.sv
module pll_freq_calc
  import pll_calc_pkg::*;
#(
  parameter int REF_W    = 32,
  parameter int RES_W    = 32,
  parameter int SCALE_SH = 10,
  parameter int DVD_W    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CW_W-1:0]  ctrl_word_i,
  input  logic [REF_W-1:0] ref_freq_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] freq_o
);
  localparam int DVS_W = (DEN_W + 1) + (PRE_W + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  pll_fields_t      fields;
  logic [DVD_W-1:0] dividend;
  logic [DVS_W-1:0] divisor;
  logic [DVD_W-1:0] quotient;
  logic             div_busy;
  logic             load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pll_field_decode u_decode (
    .ctrl_word_i (ctrl_word_i),
    .fields_o    (fields)
  );

  pll_operand_mult #(
    .REF_W(REF_W), .SCALE_SH(SCALE_SH), .DVD_W(DVD_W), .DVS_W(DVS_W)
  ) u_mult (
    .fields_i   (fields),
    .ref_freq_i (ref_freq_i),
    .dividend_o (dividend),
    .divisor_o  (divisor)
  );

  assign load = start_i & ~div_busy;

  pll_restoring_div #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
    .clk        (clk),
    .rst_ni     (rst_int_n),
    .load_i     (load),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .busy_o     (div_busy),
    .done_o     (done_o),
    .quotient_o (quotient)
  );

  assign busy_o = div_busy;
  assign freq_o = {quotient[RES_W-SCALE_SH-1:0], {SCALE_SH{1'b0}}};

  // R8: a start while busy leaves the busy state untouched
  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i && $past(busy_o)) |=> (busy_o || done_o));

  // R5: the result is always a whole multiple of the scale step
  assert_scaled_result_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> (freq_o[SCALE_SH-1:0] == '0));
endmodule

// File: tb/pll_freq_calc_tb_top.sv
module pll_freq_calc_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] ctrl_word_i;
  logic [31:0] ref_freq_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] freq_o;

  int checks   = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_result;

  pll_freq_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ctrl_word_i(ctrl_word_i),
    .ref_freq_i(ref_freq_i), .busy_o(busy_o), .done_o(done_o), .freq_o(freq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mk_word(int pre, int den, int mul, int num, logic [31:0] junk);
    logic [31:0] w;
    w = junk & 32'hC000_C000;
    w[29:26] = pre[3:0];
    w[25:16] = den[9:0];
    w[13:10] = mul[3:0];
    w[9:0]   = num[9:0];
    return w;
  endfunction

  function automatic logic [31:0] model(logic [31:0] w, logic [31:0] rf);
    longint num, mul, den, pre, term, q;
    longint unsigned dvd;
    num = longint'(w[9:0]);
    if (w[9]) num = num - 1024;
    mul = longint'(w[13:10]);
    if (mul < 5) mul = 5;
    den = longint'(w[25:16]) + 1;
    pre = longint'(w[29:26]) + 1;
    term = mul * den + num;
    if (term < 0) return 32'd0;
    dvd = 2 * longint'(rf >> 10) * term;
    q = longint'(dvd / longint'(den * pre));
    return 32'(q << 10);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // driver: issues one calculation and measures its latency (R7)
  task automatic run(string tag, logic [31:0] w, logic [31:0] rf, logic [31:0] exp);
    int k;
    int busy_cnt;
    while (busy_o) @(negedge clk);
    ctrl_word_i = w;
    ref_freq_i  = rf;
    start_i     = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    k = 0;
    busy_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    ctrl_word_i = ~w;
    k = 1;
    if (busy_o) busy_cnt++;
    while (!done_o && k < 200) begin
      @(negedge clk);
      k++;
      if (busy_o) busy_cnt++;
    end
    check({tag, " R7 latency"}, 32'(k), 32'd65);
    check({tag, " R7 busy cycles"}, 32'(busy_cnt), 32'd64);
    check({tag, " R7 busy low at done"}, {31'd0, busy_o}, 32'd0);
  endtask

  // monitor: compares each done against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected done", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), freq_o, exp_q.pop_front());
        last_result = freq_o;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    start_i = 1'b0;
    ctrl_word_i = '0;
    ref_freq_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R10 done after reset", {31'd0, done_o}, 32'd0);
    check("R10 result after reset", freq_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 idle after release", {30'd0, busy_o, done_o}, 32'd0);

    // R4 main reset setting, fixed vector
    run("R4 main setting", mk_word(1, 0, 6, 0, 32'h0), 32'd26000000, 32'd155996160);
    // R1 secondary setting, back-to-back start in the done cycle (R9)
    run("R1 secondary setting", mk_word(1, 4, 12, 1, 32'h0), 32'd26000000,
        model(mk_word(1, 4, 12, 1, 32'h0), 32'd26000000));
    // R2 clamp: multipliers 0 and 4 act as 5
    run("R2 clamp mul=0", mk_word(0, 0, 0, 0, 32'h0), 32'd26000000, 32'd259993600);
    run("R2 clamp mul=4", mk_word(0, 0, 4, 0, 32'h0), 32'd26000000, 32'd259993600);
    // R3 negative numerator, inexact quotient
    run("R3 negative numerator", mk_word(2, 2, 10, 1017, 32'h0), 32'd26000000, 32'd132885504);
    // R1 unused bits set have no effect
    w = mk_word(1, 0, 6, 0, 32'hFFFF_FFFF);
    run("R1 ignored bits", w, 32'd26000000, 32'd155996160);
    // R1 largest codes
    run("R1 max codes", mk_word(15, 1023, 15, 511, 32'h0), 32'd19200000,
        model(mk_word(15, 1023, 15, 511, 32'h0), 32'd19200000));
    // R5 wrap of the scaled quotient
    run("R5 wrap", mk_word(0, 0, 15, 511, 32'h0), 32'hFFFF_FFFF,
        model(mk_word(0, 0, 15, 511, 32'h0), 32'hFFFF_FFFF));
    // R6 negative term gives zero
    run("R6 negative term", mk_word(0, 0, 5, 512, 32'h0), 32'd26000000, 32'd0);
    // R4 low reference below one scale step
    run("R4 tiny reference", mk_word(1, 0, 6, 0, 32'h0), 32'd1000, 32'd0);

    // R9 hold while idle with changing inputs
    run("R4 hold setup", mk_word(3, 7, 9, 100, 32'h0), 32'd33554432,
        model(mk_word(3, 7, 9, 100, 32'h0), 32'd33554432));
    ctrl_word_i = 32'h1234_5678;
    ref_freq_i  = 32'h0BAD_F00D;
    repeat (8) @(negedge clk);
    check("R9 result held", freq_o, last_result);

    // R8 start while busy is ignored
    while (busy_o) @(negedge clk);
    ctrl_word_i = mk_word(1, 0, 6, 0, 32'h0);
    ref_freq_i  = 32'd26000000;
    start_i = 1'b1;
    exp_q.push_back(32'd155996160);
    tag_q.push_back("R8 ignored start");
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    ctrl_word_i = mk_word(0, 0, 15, 0, 32'h0);
    ref_freq_i  = 32'hFFFF_0000;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    @(negedge clk);
    check("R8 no second run", {31'd0, busy_o}, 32'd0);
    repeat (70) @(negedge clk);
    check("R8 no extra done", {31'd0, done_o}, 32'd0);
    check("R8 scoreboard drained", 32'(exp_q.size()), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule